// File: doc/BRIEF.md
# Single-cycle 32-bit load/store core

This block is a small 32-bit processor core. It completes each instruction in a single clock cycle. In that cycle it fetches the instruction word, decodes it, reads up to two registers, runs the ALU, accesses data memory and writes back. The supported operations are:

- register-to-register add, subtract, AND, OR and signed set-less-than;
- load word and store word, addressed as base register plus a signed 16-bit offset;
- branch when two registers are equal;
- an absolute jump that keeps the top four bits of the PC;
- a jump through a register.

Instruction and data memory sit outside the core. The instruction port is a combinational read: the core drives the PC as a byte address and receives the word. The data port presents an address, store data and a write enable, and the write takes effect at the next rising edge. The load data returns combinationally in the same cycle. A register peek port gives combinational read access to any register, so a bench can compare architectural state.

Top module: `sc_core`

## Requirements
- R1: While the synchronous active-high reset is high at a rising edge, the PC becomes 0 and every register becomes 0.
- R2: An R-format word (opcode 000000, shamt [10:6] equal to 0) writes rd [15:11] with the result of rs [25:21] and rt [20:16]. The operation is chosen by funct [5:0]: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 signed less-than giving 1 or 0. Add and subtract wrap modulo 2^32.
- R3: Opcode 100011 loads the data word at byte address rs + sign-extended [15:0] into register rt.
- R4: Opcode 101011 writes rt to data memory at byte address rs + sign-extended [15:0] and changes no register.
- R5: Opcode 000100 sets the next PC to PC+4+(sign-extended [15:0] shifted left 2) when rs equals rt, and to PC+4 otherwise.
- R6: Opcode 000010 sets the next PC to PC[31:28], then field [25:0], then two zero bits.
- R7: An R-format word with funct 001000 loads the PC from rs and writes no register, whatever its rd field holds.
- R8: Register 0 always reads as 0, and a write aimed at it has no effect.
- R9: Any other opcode, any other funct, or a nonzero shamt in an R-format word leaves registers and data memory unchanged and advances the PC by 4. Every non-control instruction also advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | output | 32 | Current PC, byte address of the instruction |
| fetch_word | input | 32 | Instruction word at fetch_addr |
| mem_addr | output | 32 | Data memory byte address |
| mem_wdata | output | 32 | Store data |
| mem_wen | output | 1 | Store enable; memory writes at the rising edge |
| mem_rdata | input | 32 | Load data at mem_addr |
| peek_idx | input | 5 | Register index for the peek port |
| peek_val | output | 32 | Value of register peek_idx |

## Verification
The bench builds the core with its default parameters: 32-bit words and a 32-entry register file. It uses a 256-word data array, so the base-plus-offset window around address 0x100, including negative offsets, stays inside the memory. With operands loaded from data memory, including 0x7FFFFFFF, 0x80000000 and all-ones, every ALU function is swept over all 36 ordered pairs of six source registers, with destinations that sometimes land on register 0. The control-flow cases cover both branch outcomes and a negative branch offset. They also cover a register jump into the top address segment, followed by an absolute jump that must keep those top four bits.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN   = 32;
    localparam int REG_N  = 32;
    localparam int REG_AW = $clog2(REG_N);

    localparam logic [5:0] OPC_ALU   = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JMP   = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;
    localparam logic [5:0] FN_JR  = 6'b001000;

    // class of ALU work requested by the main decoder
    typedef enum logic [1:0] {
        AC_ADD   = 2'b00,
        AC_SUB   = 2'b01,
        AC_FUNCT = 2'b10
    } alu_class_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_sel_e;

    typedef struct packed {
        logic       dst_rd;   // destination from rd instead of rt
        logic       src_imm;  // second ALU operand is the extended offset
        logic       wb_mem;   // write back load data instead of ALU result
        logic       reg_wr;
        logic       mem_wr;
        logic       br_eq;
        logic       jmp;
        alu_class_e alu_cls;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl,
    output alu_sel_e    alu_sel,
    output logic        is_jr,
    output logic        reg_we
);

    logic [5:0] opc;
    logic [5:0] fn;
    logic       shamt_zero;
    logic       fn_ok;

    assign opc        = instr[31:26];
    assign fn         = instr[5:0];
    assign shamt_zero = (instr[10:6] == 5'd0);

    // main decoder
    always_comb begin
        ctrl = '0;
        case (opc)
            OPC_ALU: begin
                ctrl.dst_rd  = 1'b1;
                ctrl.reg_wr  = 1'b1;
                ctrl.alu_cls = AC_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.src_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
                ctrl.reg_wr  = 1'b1;
            end
            OPC_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.br_eq   = 1'b1;
                ctrl.alu_cls = AC_SUB;
            end
            OPC_JMP: begin
                ctrl.jmp = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

    // funct-level decoder
    always_comb begin
        alu_sel = ALU_ADD;
        fn_ok   = 1'b0;
        is_jr   = 1'b0;
        case (ctrl.alu_cls)
            AC_ADD: alu_sel = ALU_ADD;
            AC_SUB: alu_sel = ALU_SUB;
            AC_FUNCT: begin
                case (fn)
                    FN_ADD: begin alu_sel = ALU_ADD; fn_ok = shamt_zero; end
                    FN_SUB: begin alu_sel = ALU_SUB; fn_ok = shamt_zero; end
                    FN_AND: begin alu_sel = ALU_AND; fn_ok = shamt_zero; end
                    FN_OR:  begin alu_sel = ALU_OR;  fn_ok = shamt_zero; end
                    FN_SLT: begin alu_sel = ALU_SLT; fn_ok = shamt_zero; end
                    FN_JR:  is_jr = shamt_zero;
                    default: fn_ok = 1'b0;
                endcase
            end
            default: alu_sel = ALU_ADD;
        endcase
    end

    assign reg_we = ctrl.reg_wr && ((ctrl.alu_cls != AC_FUNCT) || fn_ok);

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_sel_e     sel,
    output logic [W-1:0] y,
    output logic         zero
);

    logic [W-1:0] diff;
    logic         lt;

    assign diff = a - b;
    assign lt   = ($signed(a) < $signed(b));

    always_comb begin
        case (sel)
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, lt};
            default: y = '0;
        endcase
    end

    assign zero = (diff == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] pa,
    output logic [W-1:0]  pd
);

    logic [W-1:0] regs_d [DEPTH];
    logic [W-1:0] regs_q [DEPTH];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d[wa] = wd;
        end
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs_d[i] = '0;
            end
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
    assign pd  = (pa  == '0) ? '0 : regs_q[pa];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [XLEN-1:0]   fetch_addr,
    input  logic [31:0]       fetch_word,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              mem_wen,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic [REG_AW-1:0] peek_idx,
    output logic [XLEN-1:0]   peek_val
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_st_t;

    core_st_t st_d;
    core_st_t st_q;

    ctrl_t           ctrl;
    alu_sel_e        alu_sel;
    logic            is_jr;
    logic            rf_we;
    logic [4:0]      f_rs;
    logic [4:0]      f_rt;
    logic [4:0]      f_rd;
    logic [4:0]      wr_idx;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] wb_val;
    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] pc_br;
    logic [XLEN-1:0] pc_jmp;

    assign f_rs    = fetch_word[25:21];
    assign f_rt    = fetch_word[20:16];
    assign f_rd    = fetch_word[15:11];
    assign imm_ext = {{(XLEN-16){fetch_word[15]}}, fetch_word[15:0]};

    sc_decode u_dec (
        .instr   (fetch_word),
        .ctrl    (ctrl),
        .alu_sel (alu_sel),
        .is_jr   (is_jr),
        .reg_we  (rf_we)
    );

    assign wr_idx = ctrl.dst_rd ? f_rd : f_rt;

    sc_regfile #(
        .W     (XLEN),
        .DEPTH (REG_N)
    ) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (f_rs),
        .ra2 (f_rt),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .we  (rf_we),
        .wa  (wr_idx),
        .wd  (wb_val),
        .pa  (peek_idx),
        .pd  (peek_val)
    );

    assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

    sc_alu #(
        .W (XLEN)
    ) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .sel  (alu_sel),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wb_val    = ctrl.wb_mem ? mem_rdata : alu_y;
    assign mem_addr  = alu_y;
    assign mem_wdata = rt_val;
    assign mem_wen   = ctrl.mem_wr;

    assign pc_seq = st_q.pc + XLEN'(4);
    assign pc_br  = pc_seq + {imm_ext[XLEN-3:0], 2'b00};
    assign pc_jmp = {st_q.pc[XLEN-1:XLEN-4], fetch_word[25:0], 2'b00};

    always_comb begin
        st_d.pc = pc_seq;
        if (ctrl.br_eq && alu_zero) begin
            st_d.pc = pc_br;
        end
        if (ctrl.jmp) begin
            st_d.pc = pc_jmp;
        end
        if (is_jr) begin
            st_d.pc = rs_val;
        end
        if (rst) begin
            st_d.pc = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fetch_addr = st_q.pc;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        reg_we,
    input logic        mem_we,
    input logic [4:0]  peek_idx,
    input logic [31:0] peek_val
);

    logic is_rfmt;
    logic is_jr_word;
    logic is_seq;

    assign is_rfmt    = (instr[31:26] == OPC_ALU);
    assign is_jr_word = is_rfmt && (instr[5:0] == FN_JR) && (instr[10:6] == 5'd0);
    assign is_seq     = !is_rfmt && (instr[31:26] != OPC_BEQ) && (instr[31:26] != OPC_JMP);

    assert_reset_pc_R1: assert property (@(posedge clk)
        rst |=> (pc == 32'd0));

    assert_store_no_regwrite_R4: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_STORE) |-> (mem_we && !reg_we));

    assert_branch_target_R5: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_BEQ) |=> (pc == $past(pc + 32'd4 +
            ((rs_val == rt_val) ? {{14{instr[15]}}, instr[15:0], 2'b00} : 32'd0))));

    assert_jump_target_R6: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_JMP) |=> (pc == $past({pc[31:28], instr[25:0], 2'b00})));

    assert_jr_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        is_jr_word |-> !reg_we);

    assert_jr_target_R7: assert property (@(posedge clk) disable iff (rst)
        is_jr_word |=> (pc == $past(rs_val)));

    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (rst)
        (peek_idx == 5'd0) |-> (peek_val == 32'd0));

    assert_seq_pc_R9: assert property (@(posedge clk) disable iff (rst)
        is_seq |=> (pc == $past(pc) + 32'd4));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc       (fetch_addr),
    .instr    (fetch_word),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .reg_we   (rf_we),
    .mem_we   (mem_wen),
    .peek_idx (peek_idx),
    .peek_val (peek_val)
);

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;
    import sc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_word = 32'd0;
    logic [31:0] fetch_addr;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_wen;
    logic [31:0] mem_rdata;
    logic [4:0]  peek_idx = 5'd0;
    logic [31:0] peek_val;

    logic [31:0] dmem [256];
    logic [31:0] mreg [32];
    logic [31:0] mpc;
    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sc_core dut (
        .clk        (clk),
        .rst        (rst),
        .fetch_addr (fetch_addr),
        .fetch_word (fetch_word),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_wen    (mem_wen),
        .mem_rdata  (mem_rdata),
        .peek_idx   (peek_idx),
        .peek_val   (peek_val)
    );

    assign mem_rdata = dmem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (mem_wen) dmem[mem_addr[9:2]] <= mem_wdata;
    end

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [4:0] sh,
                                          input logic [5:0] fn);
        return {OPC_ALU, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input int idx);
        peek_idx = 5'(idx);
        #1;
        chk(req, peek_val, mreg[idx]);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // applies one instruction at a falling edge, updates the ISA model,
    // and checks the PC after the rising edge
    task automatic step(input logic [31:0] ins, input string req);
        logic [5:0]  op;
        logic [4:0]  rs, rt, rd;
        logic [31:0] sx, va, vb, npc, ea, wv;
        logic [4:0]  wi;
        logic        we;
        op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        sx = {{16{ins[15]}}, ins[15:0]};
        va = mreg[rs]; vb = mreg[rt];
        npc = mpc + 32'd4; ea = va + sx;
        we = 1'b0; wi = 5'd0; wv = 32'd0;
        fetch_word = ins;
        case (op)
            OPC_ALU: if (ins[10:6] == 5'd0) begin
                case (ins[5:0])
                    FN_ADD: begin we = 1'b1; wi = rd; wv = va + vb; end
                    FN_SUB: begin we = 1'b1; wi = rd; wv = va - vb; end
                    FN_AND: begin we = 1'b1; wi = rd; wv = va & vb; end
                    FN_OR:  begin we = 1'b1; wi = rd; wv = va | vb; end
                    FN_SLT: begin we = 1'b1; wi = rd; wv = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0; end
                    FN_JR:  npc = va;
                    default: we = 1'b0;
                endcase
            end
            OPC_LOAD: begin we = 1'b1; wi = rt; wv = dmem[ea[9:2]]; end
            OPC_BEQ:  if (va == vb) npc = mpc + 32'd4 + (sx << 2);
            OPC_JMP:  npc = {mpc[31:28], ins[25:0], 2'b00};
            default:  we = 1'b0;
        endcase
        @(posedge clk);
        @(negedge clk);
        if (we && wi != 5'd0) mreg[wi] = wv;
        mpc = npc;
        chk(req, fetch_addr, mpc);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = (i * 32'h01010101) ^ 32'hA5A50000;
        dmem[0]  = 32'h00000100;
        dmem[1]  = 32'h7FFFFFFF;
        dmem[2]  = 32'h80000000;
        dmem[3]  = 32'h00000005;
        dmem[4]  = 32'hFFFFFFFD;
        dmem[5]  = 32'h00000000;
        dmem[6]  = 32'hFFFFFFFF;
        dmem[7]  = 32'h12345678;
        dmem[8]  = 32'h00000001;
        dmem[9]  = 32'h0F0F00F0;
        dmem[10] = 32'h80000001;
        dmem[11] = 32'hF0000010;
        for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
        mpc = 32'd0;

        // R1: state during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pc", fetch_addr, 32'd0);
        for (int i = 0; i < 32; i++) chk_reg("R1 reg", i);
        rst = 1'b0;

        // R3: load operands from data memory
        for (int i = 1; i <= 10; i++) begin
            step(enc_i(OPC_LOAD, 5'd0, 5'(i), 16'(i * 4)), "R3 pc");
            chk_reg("R3 load", i);
        end
        step(enc_i(OPC_LOAD, 5'd0, 5'd20, 16'd0), "R3 pc");
        chk_reg("R3 load", 20);
        step(enc_i(OPC_LOAD, 5'd0, 5'd22, 16'd44), "R3 pc");
        chk_reg("R3 load", 22);

        // R2/R8: every function over all source pairs
        for (int f = 0; f < 5; f++) begin
            for (int a = 1; a <= 6; a++) begin
                for (int b = 1; b <= 6; b++) begin
                    logic [5:0] fn;
                    int rd;
                    case (f)
                        0: fn = FN_ADD;
                        1: fn = FN_SUB;
                        2: fn = FN_AND;
                        3: fn = FN_OR;
                        default: fn = FN_SLT;
                    endcase
                    rd = (a * 3 + b + f) % 11;
                    step(enc_r(5'(a), 5'(b), 5'(rd), 5'd0, fn), "R9 pc");
                    chk_reg((rd == 0) ? "R8 dest r0" : "R2 result", rd);
                end
            end
        end
        step(enc_r(5'd2, 5'd6, 5'd0, 5'd0, FN_OR), "R9 pc");
        chk_reg("R8 read r0", 0);

        // R4: stores around the base, both offset signs
        for (int k = 0; k < 9; k++) begin
            logic [31:0] ea;
            logic [15:0] off;
            off = 16'((k - 4) * 4);
            ea = mreg[20] + {{16{off[15]}}, off};
            step(enc_i(OPC_STORE, 5'd20, 5'(k + 1), off), "R4 pc");
            chk("R4 store data", dmem[ea[9:2]], mreg[k + 1]);
            chk_reg("R4 no reg write", k + 1);
        end
        // R3: read them back with the same offsets
        for (int k = 0; k < 9; k++) begin
            step(enc_i(OPC_LOAD, 5'd20, 5'(k + 11), 16'((k - 4) * 4)), "R3 pc");
            chk_reg("R3 load back", k + 11);
        end

        // R5: branch taken, not taken, negative offset
        step(enc_i(OPC_BEQ, 5'd0, 5'd0, 16'd3), "R5 taken");
        step(enc_i(OPC_BEQ, 5'd20, 5'd0, 16'd7), "R5 not taken");
        step(enc_i(OPC_BEQ, 5'd1, 5'd1, 16'hFFFB), "R5 negative");
        step(enc_i(OPC_BEQ, 5'd22, 5'd20, 16'h8000), "R5 not taken far");

        // R6/R7: jumps
        step({OPC_JMP, 26'h0000040}, "R6 jump");
        step(enc_r(5'd22, 5'd0, 5'd5, 5'd0, FN_JR), "R7 jr target");
        chk_reg("R7 jr no write", 5);
        step({OPC_JMP, 26'h0000123}, "R6 keeps upper bits");
        step({OPC_JMP, 26'h3FFFFFF}, "R6 full field");

        // R9: words that must change nothing but the PC
        step(enc_i(6'b001000, 5'd1, 5'd7, 16'd5), "R9 pc");
        chk_reg("R9 unknown opcode", 7);
        step(enc_r(5'd1, 5'd2, 5'd6, 5'd0, 6'b000000), "R9 pc");
        chk_reg("R9 unknown funct", 6);
        step(enc_r(5'd1, 5'd2, 5'd4, 5'd3, FN_ADD), "R9 pc");
        chk_reg("R9 nonzero shamt", 4);

        for (int i = 0; i < 32; i++) chk_reg("R2 final state", i);

        // R1: reset from a running state
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
        chk("R1 pc after reset", fetch_addr, 32'd0);
        for (int i = 0; i < 32; i++) chk_reg("R1 reg after reset", i);

        summary();
        $finish;
    end

endmodule